// File: doc/BRIEF.md
# Reservation Table Collision Analyzer

This block holds the reservation table of one pipeline function as a bit matrix. The matrix has one row per stage and one bit per time column. Column j of a row is set when that stage is busy in cycle j+1 of an evaluation. Software or a neighbouring block loads the rows one at a time through a plain write port. It then pulses `start`.

After the pulse the block tests one latency per clock, from 1 up to COLS-1. A latency d collides when some row is marked in two columns that are d apart. Each result goes into the collision vector: bit d-1 set means latency d is forbidden. When the scan ends, the block has three results:
- the collision vector;
- the largest forbidden latency, or 0 when every latency is permissible;
- the largest mark count in any single row, which is the lower bound on the minimum average latency.

It raises `done` with them. The write port is always accepted while the block is idle, so it has no back-pressure. While a scan runs, writes and further start pulses are dropped.

Top module: `rt_collision_analyzer`

## Requirements
- R1: After reset, `done`, `cv`, `max_forbidden` and `max_row_marks` are all zero.
- R2: While idle, a cycle with `wr_en` high stores `wr_row` as the row of stage `wr_stage`. Bit j of `wr_row` is column j (cycle j+1). A write during a scan is dropped and does not change later results.
- R3: A `start` seen while idle clears `done` at that edge. `done` then rises exactly COLS-1 clock edges later and stays high until the next accepted `start`.
- R4: When `done` is high, `cv` bit d-1 is 1 exactly when some row has marks in two columns j and j+d, for 1 ≤ d ≤ COLS-1.
- R5: When `done` is high, `max_forbidden` is the largest forbidden latency, or 0 if none exists. When it is nonzero, `cv` bit `max_forbidden`-1 is 1 and every higher bit is 0.
- R6: When `done` is high, `max_row_marks` is the largest number of set bits in any row, taken from the table as it stood when `start` was accepted.
- R7: A `start` pulse during a scan is ignored. It neither restarts nor delays the scan.
- R8: A table with at most one mark per row gives `cv` = 0 and `max_forbidden` = 0. `done` is still raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Row write strobe |
| wr_stage | input | max(1,clog2(STAGES)) | Stage index of the row written |
| wr_row | input | COLS | Column bitmask of that stage |
| start | input | 1 | Begin a scan (pulse) |
| done | output | 1 | Results valid |
| cv | output | COLS-1 | Collision vector, bit d-1 for latency d |
| max_forbidden | output | clog2(COLS) | Largest forbidden latency, 0 if none |
| max_row_marks | output | clog2(COLS+1) | Largest mark count of a row |

## Verification
The hardest cases to reach are inputs that arrive while a scan is running. The rows could be rewritten and the scan restarted, and neither may happen. The stimulus loads a table and starts a scan. Halfway through that scan it issues both a conflicting row write and a second start pulse. It then rescans without reloading. The reference model ignores both intruders, so the done timing and the rescan results expose any leak. The three-stage example with forbidden latencies 2, 4, 5 and 7 gives a known vector. A single-mark table and a dense table give the two extremes.

// File: rtl/rca_pkg.sv
package rca_pkg;
  typedef enum logic [0:0] {S_IDLE, S_SCAN} scan_state_t;
endpackage

// File: rtl/rca_table.sv
module rca_table #(
  parameter int STAGES = 3,
  parameter int COLS   = 8,
  localparam int SW = (STAGES > 1) ? $clog2(STAGES) : 1,
  localparam int MW = $clog2(COLS + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [SW-1:0]          wr_stage,
  input  logic [COLS-1:0]        wr_row,
  input  logic                   lock,
  output logic [STAGES*COLS-1:0] rows_flat,
  output logic [MW-1:0]          peak_marks
);
  logic [MW-1:0] row_cnt [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_row
    logic [COLS-1:0] row_q;
    always_ff @(posedge clk) begin
      if (!rst_n) row_q <= '0;
      else if (wr_en && !lock && wr_stage == SW'(s)) row_q <= wr_row;
    end
    assign rows_flat[s*COLS +: COLS] = row_q;
    always_comb begin
      row_cnt[s] = '0;
      for (int c = 0; c < COLS; c++) row_cnt[s] = row_cnt[s] + MW'(row_q[c]);
    end
  end

  always_comb begin
    peak_marks = '0;
    for (int s = 0; s < STAGES; s++)
      if (row_cnt[s] > peak_marks) peak_marks = row_cnt[s];
  end

  assert_locked_rows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable(rows_flat));
endmodule

// File: rtl/rca_overlap.sv
module rca_overlap #(
  parameter int STAGES = 3,
  parameter int COLS   = 8,
  localparam int DW = $clog2(COLS)
) (
  input  logic [STAGES*COLS-1:0] rows_flat,
  input  logic [DW-1:0]          lat,
  output logic                   hit
);
  logic [STAGES-1:0] stage_hit;
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [COLS-1:0] r;
    assign r = rows_flat[s*COLS +: COLS];
    assign stage_hit[s] = |(r & (r >> lat));
  end
  assign hit = |stage_hit;
endmodule

// File: rtl/rca_ctrl.sv
module rca_ctrl
  import rca_pkg::*;
#(
  parameter int COLS = 8,
  localparam int DW = $clog2(COLS),
  localparam int MW = $clog2(COLS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            hit,
  input  logic [MW-1:0]   peak_marks,
  output logic [DW-1:0]   lat,
  output logic            lock,
  output logic            done,
  output logic [COLS-2:0] cv,
  output logic [DW-1:0]   max_forbidden,
  output logic [MW-1:0]   max_row_marks
);
  scan_state_t state;
  localparam logic [DW-1:0] LAST = DW'(COLS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE; lat <= '0; cv <= '0; done <= 1'b0;
      max_forbidden <= '0; max_row_marks <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state <= S_SCAN; lat <= DW'(1); cv <= '0; done <= 1'b0;
          max_forbidden <= '0; max_row_marks <= peak_marks;
        end
        S_SCAN: begin
          cv[lat - DW'(1)] <= hit;
          if (hit) max_forbidden <= lat;
          if (lat == LAST) begin
            state <= S_IDLE; done <= 1'b1;
          end else lat <= lat + DW'(1);
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign lock = (state == S_SCAN);

  assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SCAN && start && lat != LAST) |=> (state == S_SCAN && lat == $past(lat) + DW'(1)));
  assert_top_bit_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && max_forbidden != '0) |-> cv[max_forbidden - DW'(1)]);
  assert_above_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((cv >> max_forbidden) == '0));
  assert_sparse_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && max_row_marks <= MW'(1)) |-> (cv == '0 && max_forbidden == '0));
  assert_done_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> state == S_IDLE);
endmodule

// File: rtl/rt_collision_analyzer.sv
module rt_collision_analyzer #(
  parameter int STAGES = 3,
  parameter int COLS   = 8,
  localparam int SW = (STAGES > 1) ? $clog2(STAGES) : 1,
  localparam int DW = $clog2(COLS),
  localparam int MW = $clog2(COLS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [SW-1:0]   wr_stage,
  input  logic [COLS-1:0] wr_row,
  input  logic            start,
  output logic            done,
  output logic [COLS-2:0] cv,
  output logic [DW-1:0]   max_forbidden,
  output logic [MW-1:0]   max_row_marks
);
  logic [STAGES*COLS-1:0] rows_flat;
  logic [MW-1:0]          peak_marks;
  logic [DW-1:0]          lat;
  logic                   lock, hit;

  rca_table #(.STAGES(STAGES), .COLS(COLS)) u_table (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_stage(wr_stage), .wr_row(wr_row),
    .lock(lock), .rows_flat(rows_flat), .peak_marks(peak_marks));

  rca_overlap #(.STAGES(STAGES), .COLS(COLS)) u_overlap (
    .rows_flat(rows_flat), .lat(lat), .hit(hit));

  rca_ctrl #(.COLS(COLS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .hit(hit), .peak_marks(peak_marks),
    .lat(lat), .lock(lock), .done(done), .cv(cv),
    .max_forbidden(max_forbidden), .max_row_marks(max_row_marks));
endmodule

// File: tb/rt_collision_analyzer_test.sv
module rt_collision_analyzer_test;
  localparam int STAGES = 3;
  localparam int COLS = 8;
  localparam int SW = (STAGES > 1) ? $clog2(STAGES) : 1;
  localparam int DW = $clog2(COLS);
  localparam int MW = $clog2(COLS + 1);

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, start = 1'b0;
  logic [SW-1:0] wr_stage = '0;
  logic [COLS-1:0] wr_row = '0;
  logic done;
  logic [COLS-2:0] cv;
  logic [DW-1:0] max_forbidden;
  logic [MW-1:0] max_row_marks;

  int tests = 0, fails = 0, cycles = 0;

  rt_collision_analyzer #(.STAGES(STAGES), .COLS(COLS)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_stage(wr_stage), .wr_row(wr_row),
    .start(start), .done(done), .cv(cv), .max_forbidden(max_forbidden),
    .max_row_marks(max_row_marks));

  always #5 clk = ~clk;

  // behavioural reference
  int mrow [STAGES];
  bit mbusy = 0, mdone = 0;
  int mcnt = 0, exp_cv = 0, exp_mf = 0, exp_mk = 0;

  task automatic analyse(output int vcv, output int vmf, output int vmk);
    vcv = 0; vmf = 0; vmk = 0;
    for (int s = 0; s < STAGES; s++) begin
      int n = 0;
      for (int j = 0; j < COLS; j++) begin
        if (mrow[s][j]) n++;
        for (int d = 1; j + d < COLS; d++)
          if (mrow[s][j] && mrow[s][j+d]) begin
            vcv |= (1 << (d - 1));
            if (d > vmf) vmf = d;
          end
      end
      if (n > vmk) vmk = n;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      mbusy = 0; mdone = 0; mcnt = 0;
      for (int s = 0; s < STAGES; s++) mrow[s] = 0;
    end else begin
      if (wr_en && !mbusy) mrow[wr_stage] = int'(wr_row);
      if (!mbusy) begin
        if (start) begin
          mbusy = 1; mdone = 0; mcnt = 0;
          analyse(exp_cv, exp_mf, exp_mk);
        end
      end else begin
        mcnt++;
        if (mcnt == COLS - 1) begin mbusy = 0; mdone = 1; end
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // compare on every clock, away from the edge
  always @(negedge clk) if (rst_n) begin
    check("R3 done", int'(done), int'(mdone));
    if (mdone && done) begin
      check("R4 cv", int'(cv), exp_cv);
      check("R5 max_forbidden", int'(max_forbidden), exp_mf);
      check("R6 max_row_marks", int'(max_row_marks), exp_mk);
    end
  end

  task automatic wr(int s, int row);
    @(negedge clk); wr_en = 1; wr_stage = SW'(s); wr_row = COLS'(row);
    @(negedge clk); wr_en = 0;
  endtask

  task automatic run_scan();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    check("R3 done cleared", int'(done), 0);
    repeat (COLS - 1) @(negedge clk);
    check("R3 done raised", int'(done), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 done", int'(done), 0);
    check("R1 cv", int'(cv), 0);
    check("R1 max_forbidden", int'(max_forbidden), 0);
    check("R1 max_row_marks", int'(max_row_marks), 0);
    rst_n = 1;

    // example function: forbidden 2,4,5,7
    wr(0, 'hA1); wr(1, 'h0A); wr(2, 'h54);
    run_scan();
    check("R4 example cv", int'(cv), 'h5A);
    check("R5 example max", int'(max_forbidden), 7);
    check("R6 example marks", int'(max_row_marks), 3);

    // sparse table
    wr(0, 'h01); wr(1, 'h10); wr(2, 'h00);
    run_scan();
    check("R8 sparse cv", int'(cv), 0);
    check("R8 sparse max", int'(max_forbidden), 0);

    // dense row: every latency forbidden
    wr(1, 'hFF);
    run_scan();
    check("R4 dense cv", int'(cv), 'h7F);
    check("R6 dense marks", int'(max_row_marks), 8);

    // intruders mid-scan: write and second start are dropped
    wr(1, 'h05);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    repeat (2) @(negedge clk);
    wr_en = 1; wr_stage = 2; wr_row = 'h81; start = 1;
    @(negedge clk); wr_en = 0; start = 0;
    repeat (COLS) @(negedge clk);
    check("R7 single done", int'(done), 1);
    check("R7 max after restart attempt", int'(max_forbidden), 2);
    run_scan();
    check("R2 dropped write cv", int'(cv), 'h02);
    check("R2 dropped write max", int'(max_forbidden), 2);

    // a write while idle does take effect
    wr(2, 'h81);
    run_scan();
    check("R2 idle write cv", int'(cv), 'h42);
    check("R5 idle write max", int'(max_forbidden), 7);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      tests++; fails++;
      $display("FAIL watchdog: actual %0d expected below 20000", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule